// File: doc/BRIEF.md
# Transmit Slot Queue with Busy Bitmap

This block holds a small set of transmit packet slots in local memory and sends them out as a byte stream. A host owns a slot while its busy bit is clear. It opens a fill with a command word that names the slot and pushes the frame through a word-wide data port. It then closes the fill, sets the slot's busy bit and writes the slot's descriptor with an enable flag and the frame length. The engine sends ready slots one at a time and clears the busy bit once the last byte has left, which is what the host polls to find a free slot.

A slot is ready when its busy bit and its descriptor enable are both set. The dispatcher searches the slots in circular index order, starting one past the slot it last sent (slot 0 after reset), so a host that uses slots round-robin sees its frames leave in the order it queued them. Both the fill port and the byte output are valid/ready streams. A word is taken on a cycle where `fill_valid` and `fill_ready` are both high. A byte leaves on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low the engine holds the same byte, and it never withdraws `tx_valid`.

Top module: `txq_engine`

## Requirements
- R1: After reset `busy_map` is all zero, `tx_valid` and `fill_ready` are low, and the dispatcher's search starts at slot 0.
- R2: A register write to address 0x00 with bit 12 set opens a fill for the slot in bits 15:13. `fill_ready` is high while fewer than SLOT_BYTES/BUS_BYTES words have been taken, and words offered after that are dropped. Word i is stored as frame bytes BUS_BYTES*i and up, lowest byte in bits 7:0. A write to 0x00 with bit 12 clear closes the fill and drops `fill_ready`.
- R3: A write to address 0x04 sets every `busy_map` bit whose data bit is 1, visible the next cycle. Data bits that are 0 leave their slot's bit unchanged, and the host can never clear a bit.
- R4: Slot n's descriptor is at address 0x10 + 4*n. Bit 15 is the enable and bits 6:0 are the length in bytes. A slot whose busy bit is set but whose enable is clear is not sent.
- R5: Among the ready slots, the dispatcher picks the first one in circular index order starting one past the last slot it picked. It sends one frame at a time, and `tx_valid` rises the cycle after the pick.
- R6: A frame's bytes come out in stored order, `tx_last` is high on byte length-1, and padding bytes past the length are never sent.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R8: A descriptor length above SLOT_BYTES is treated as SLOT_BYTES.
- R9: The cycle after a frame's last byte is accepted, that slot's busy bit and descriptor enable are clear. A ready slot with length 0 is released with no bytes sent. If the host sets a bit in the same cycle that the engine releases it, the host's set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| fill_valid | input | 1 | Fill word offered |
| fill_ready | output | 1 | Fill word can be taken |
| fill_data | input | 8*BUS_BYTES | Fill word, lowest byte first in the frame |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Output byte accepted when high with tx_valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Last byte of the frame |
| busy_map | output | SLOTS | One bit per slot, set while the slot holds an unsent frame |

## Verification
The bench makes several slots ready in one bitmap write, with the search pointer near the top of the index range. A design that scans from slot 0, or that does not wrap, sends them in the wrong order. It writes a zero data word to the bitmap and sets a busy bit with no enable. A design that clears bits on zero writes, or that treats a busy bit alone as ready, loses a frame or sends an unfinished one. It streams more words into a slot than the slot holds, sends frames whose lengths are not a multiple of the bus word, and gives lengths above the slot size and a length of zero. Errors here show up as corrupted bytes, extra padding bytes, reads past the slot, or a bit that stays busy forever. Random back-pressure on the output checks that a stalled byte is neither skipped nor repeated.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 16;

  // register map
  localparam logic [ADDR_W-1:0] A_CMD  = 8'h00;
  localparam logic [ADDR_W-1:0] A_BUSY = 8'h04;
  localparam logic [ADDR_W-1:0] A_DESC = 8'h10;
  localparam int DESC_STRIDE = 4;

  // field positions
  localparam int CMD_FILL_BIT = 12;
  localparam int CMD_SLOT_LSB = 13;
  localparam int DESC_EN_BIT  = 15;

  typedef enum logic [0:0] {SEL_IDLE, SEL_SEND} send_st_e;
endpackage

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 64,
  parameter int BUS_BYTES  = 4,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int WPS    = SLOT_BYTES / BUS_BYTES,
  localparam int WPTR_W = $clog2(WPS) + 1,
  localparam int RA_W   = $clog2(SLOTS * WPS),
  localparam int LEN_W  = $clog2(SLOT_BYTES) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  input  logic                        fill_valid,
  output logic                        fill_ready,
  output logic                        ram_we,
  output logic [RA_W-1:0]             ram_waddr,
  input  logic                        rel_en,
  input  logic [IDX_W-1:0]            rel_idx,
  output logic [SLOTS-1:0]            busy,
  output logic [SLOTS-1:0]            desc_en,
  output logic [SLOTS-1:0][LEN_W-1:0] desc_len
);
  logic              cmd_wr;
  logic              fill_open;
  logic [IDX_W-1:0]  fill_slot;
  logic [WPTR_W-1:0] fill_ptr;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign cmd_wr     = reg_we && (reg_addr == A_CMD);
  assign fill_ready = fill_open && (fill_ptr < WPTR_W'(WPS));
  assign ram_we     = fill_valid && fill_ready;
  assign ram_waddr  = RA_W'(fill_slot) * RA_W'(WPS) + RA_W'(fill_ptr);

  // fill window: the command opens or closes it, accepted words advance it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_open <= 1'b0;
      fill_slot <= '0;
      fill_ptr  <= '0;
    end else if (cmd_wr) begin
      fill_open <= reg_wdata[CMD_FILL_BIT];
      fill_slot <= reg_wdata[CMD_SLOT_LSB +: IDX_W];
      fill_ptr  <= '0;
    end else if (ram_we) begin
      fill_ptr <= fill_ptr + WPTR_W'(1);
    end
  end

  // per-slot busy bit and descriptor
  for (genvar n = 0; n < SLOTS; n++) begin : g_slot
    localparam logic [ADDR_W-1:0] MY_DESC = A_DESC + ADDR_W'(n * DESC_STRIDE);
    logic             busy_q, en_q;
    logic [LEN_W-1:0] len_q;
    logic             set_hit, desc_hit, rel_hit;

    assign set_hit  = reg_we && (reg_addr == A_BUSY) && reg_wdata[n];
    assign desc_hit = reg_we && (reg_addr == MY_DESC);
    assign rel_hit  = rel_en && (rel_idx == IDX_W'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        en_q   <= 1'b0;
        len_q  <= '0;
      end else begin
        if (set_hit)      busy_q <= 1'b1;
        else if (rel_hit) busy_q <= 1'b0;
        if (desc_hit) begin
          en_q  <= reg_wdata[DESC_EN_BIT];
          len_q <= reg_wdata[LEN_W-1:0];
        end else if (rel_hit) begin
          en_q <= 1'b0;
        end
      end
    end

    assign busy[n]     = busy_q;
    assign desc_en[n]  = en_q;
    assign desc_len[n] = len_q;
  end
endmodule

// File: rtl/txq_ram.sv
module txq_ram #(
  parameter int WORDS = 128,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txq_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 64,
  parameter int BUS_BYTES  = 4,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int WPS    = SLOT_BYTES / BUS_BYTES,
  localparam int RA_W   = $clog2(SLOTS * WPS),
  localparam int LEN_W  = $clog2(SLOT_BYTES) + 1,
  localparam int BCNT_W = $clog2(SLOT_BYTES),
  localparam int BB_W   = $clog2(BUS_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0]            busy,
  input  logic [SLOTS-1:0]            desc_en,
  input  logic [SLOTS-1:0][LEN_W-1:0] desc_len,
  output logic [RA_W-1:0]             ram_raddr,
  input  logic [8*BUS_BYTES-1:0]      ram_rdata,
  output logic                        tx_valid,
  input  logic                        tx_ready,
  output logic [7:0]                  tx_data,
  output logic                        tx_last,
  output logic                        rel_en,
  output logic [IDX_W-1:0]            rel_idx
);
  send_st_e          st;
  logic [IDX_W-1:0]  head, cur, pick_idx, cand;
  logic              pick_found;
  logic [LEN_W-1:0]  len_q, eff_len;
  logic [BCNT_W-1:0] cnt;
  logic [SLOTS-1:0]  ready_vec;

  assign ready_vec = busy & desc_en;

  // circular search from head; lowest offset wins
  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    cand       = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      cand = head + IDX_W'(k);
      if (ready_vec[cand]) begin
        pick_found = 1'b1;
        pick_idx   = cand;
      end
    end
  end

  assign eff_len = (desc_len[pick_idx] > LEN_W'(SLOT_BYTES)) ? LEN_W'(SLOT_BYTES)
                                                             : desc_len[pick_idx];

  assign tx_valid  = (st == SEL_SEND);
  assign ram_raddr = RA_W'(cur) * RA_W'(WPS) + RA_W'(cnt >> BB_W);
  assign tx_data   = ram_rdata[{cnt[BB_W-1:0], 3'b000} +: 8];
  assign tx_last   = (LEN_W'(cnt) + LEN_W'(1)) == len_q;

  assign rel_en  = ((st == SEL_IDLE) && pick_found && (eff_len == '0)) ||
                   ((st == SEL_SEND) && tx_ready && tx_last);
  assign rel_idx = (st == SEL_SEND) ? cur : pick_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SEL_IDLE;
      head  <= '0;
      cur   <= '0;
      len_q <= '0;
      cnt   <= '0;
    end else begin
      case (st)
        SEL_IDLE: begin
          if (pick_found) begin
            head <= pick_idx + IDX_W'(1);
            if (eff_len != '0) begin
              st    <= SEL_SEND;
              cur   <= pick_idx;
              len_q <= eff_len;
              cnt   <= '0;
            end
          end
        end
        SEL_SEND: begin
          if (tx_ready) begin
            if (tx_last) st <= SEL_IDLE;
            else         cnt <= cnt + BCNT_W'(1);
          end
        end
        default: st <= SEL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txq_engine.sv
module txq_engine
  import txq_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 64,
  parameter int BUS_BYTES  = 4,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int WPS   = SLOT_BYTES / BUS_BYTES,
  localparam int RA_W  = $clog2(SLOTS * WPS),
  localparam int LEN_W = $clog2(SLOT_BYTES) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  input  logic                   fill_valid,
  output logic                   fill_ready,
  input  logic [8*BUS_BYTES-1:0] fill_data,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  output logic                   tx_last,
  output logic [SLOTS-1:0]       busy_map
);
  logic                        ram_we;
  logic [RA_W-1:0]             ram_waddr, ram_raddr;
  logic [8*BUS_BYTES-1:0]      ram_rdata;
  logic                        rel_en;
  logic [IDX_W-1:0]            rel_idx;
  logic [SLOTS-1:0]            desc_en;
  logic [SLOTS-1:0][LEN_W-1:0] desc_len;

  txq_regs #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .BUS_BYTES(BUS_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .ram_we(ram_we), .ram_waddr(ram_waddr),
    .rel_en(rel_en), .rel_idx(rel_idx),
    .busy(busy_map), .desc_en(desc_en), .desc_len(desc_len)
  );

  txq_ram #(.WORDS(SLOTS * WPS), .WIDTH(8 * BUS_BYTES)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(fill_data),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  txq_sched #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .BUS_BYTES(BUS_BYTES)) u_sched (
    .clk(clk), .rst_n(rst_n),
    .busy(busy_map), .desc_en(desc_en), .desc_len(desc_len),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rel_en(rel_en), .rel_idx(rel_idx)
  );
endmodule

// File: rtl/txq_engine_chk.sv
module txq_engine_chk
  import txq_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 64,
  parameter int BUS_BYTES  = 4,
  localparam int WPS    = SLOT_BYTES / BUS_BYTES,
  localparam int WPTR_W = $clog2(WPS) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic [SLOTS-1:0]  busy_map
);
  logic [WPTR_W-1:0] taken;

  // words accepted since the last command write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              taken <= '0;
    else if (reg_we && reg_addr == A_CMD)    taken <= '0;
    else if (fill_valid && fill_ready)       taken <= taken + WPTR_W'(1);
  end

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> (taken < WPTR_W'(WPS)));

  p_set_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_BUSY) |=>
      ((busy_map & $past(reg_wdata[SLOTS-1:0])) == $past(reg_wdata[SLOTS-1:0])));

  p_one_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(busy_map) & ~busy_map) <= 1);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_busy_inflight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (busy_map != '0));
endmodule

bind txq_engine txq_engine_chk #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .BUS_BYTES(BUS_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .fill_valid(fill_valid), .fill_ready(fill_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .busy_map(busy_map)
);

// File: tb/txq_engine_tb_top.sv
module txq_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 8;
  localparam int SLOT_BYTES = 64;
  localparam int BUS_BYTES  = 4;
  localparam int WPS        = SLOT_BYTES / BUS_BYTES;
  localparam int LEN_W      = 7;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   reg_we = 1'b0;
  logic [7:0]             reg_addr = '0;
  logic [15:0]            reg_wdata = '0;
  logic                   fill_valid = 1'b0;
  logic                   fill_ready;
  logic [8*BUS_BYTES-1:0] fill_data = '0;
  logic                   tx_valid;
  logic                   tx_ready = 1'b0;
  logic [7:0]             tx_data;
  logic                   tx_last;
  logic [SLOTS-1:0]       busy_map;

  txq_engine #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .BUS_BYTES(BUS_BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .busy_map(busy_map)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;
  int rdy_mode = 0;  // 0 low, 1 high, 2 random

  // ---------------- reference model ----------------
  logic [SLOTS-1:0] m_busy = '0, m_en = '0;
  int               m_dlen [SLOTS];
  logic [7:0]       m_mem  [SLOTS][SLOT_BYTES];
  bit m_send = 1'b0, m_fopen = 1'b0;
  int m_cur = 0, m_cnt = 0, m_len = 0, m_head = 0, m_fslot = 0, m_fptr = 0;

  int frm_first[$];
  int frm_len[$];
  int cur_len = 0, cur_first = 0;

  function automatic logic [7:0] gen(input int s, input int j, input int seed);
    return 8'(s * 37 + j * 5 + seed * 11 + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int rel, pk, eff, c;
    if (!rst_n) begin
      m_busy = '0; m_en = '0; m_send = 0; m_head = 0; m_fopen = 0;
      m_fptr = 0; m_fslot = 0; m_cur = 0; m_cnt = 0; m_len = 0;
      for (int n = 0; n < SLOTS; n++) m_dlen[n] = 0;
    end else begin
      rel = -1;
      if (m_send) begin
        if (tx_ready) begin
          if (m_cnt == m_len - 1) begin m_send = 0; rel = m_cur; end
          else m_cnt++;
        end
      end else begin
        pk = -1;
        for (int k = 0; k < SLOTS; k++) begin
          c = (m_head + k) % SLOTS;
          if (pk < 0 && m_busy[c] && m_en[c]) pk = c;
        end
        if (pk >= 0) begin
          eff = (m_dlen[pk] > SLOT_BYTES) ? SLOT_BYTES : m_dlen[pk];
          m_head = (pk + 1) % SLOTS;
          if (eff == 0) rel = pk;
          else begin m_send = 1; m_cur = pk; m_cnt = 0; m_len = eff; end
        end
      end
      if (fill_valid && m_fopen && m_fptr < WPS) begin
        for (int b = 0; b < BUS_BYTES; b++)
          m_mem[m_fslot][m_fptr * BUS_BYTES + b] = fill_data[8*b +: 8];
        m_fptr++;
      end
      if (rel >= 0) begin m_busy[rel] = 1'b0; m_en[rel] = 1'b0; end
      if (reg_we) begin
        if (reg_addr == 8'h00) begin
          m_fopen = reg_wdata[12]; m_fslot = int'(reg_wdata[15:13]); m_fptr = 0;
        end
        if (reg_addr == 8'h04) m_busy = m_busy | reg_wdata[SLOTS-1:0];
        for (int n = 0; n < SLOTS; n++)
          if (reg_addr == 8'(8'h10 + 4 * n)) begin
            m_en[n] = reg_wdata[15]; m_dlen[n] = int'(reg_wdata[LEN_W-1:0]);
          end
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(tx_valid === m_send, "R5", "tx_valid", tx_valid, m_send);
      if (m_send && tx_valid) begin
        chk(tx_data === m_mem[m_cur][m_cnt], "R6/R7", "tx_data", tx_data, m_mem[m_cur][m_cnt]);
        chk(tx_last === (m_cnt == m_len - 1), "R6", "tx_last", tx_last, (m_cnt == m_len - 1));
      end
      chk(busy_map === m_busy, "R3/R9", "busy_map", busy_map, m_busy);
      chk(fill_ready === (m_fopen && m_fptr < WPS), "R2", "fill_ready", fill_ready,
          (m_fopen && m_fptr < WPS));
      if (tx_valid && tx_ready) begin
        if (cur_len == 0) cur_first = int'(tx_data);
        cur_len++;
        if (tx_last) begin
          frm_first.push_back(cur_first); frm_len.push_back(cur_len); cur_len = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rdy_mode == 0)      tx_ready <= 1'b0;
    else if (rdy_mode == 1) tx_ready <= 1'b1;
    else                    tx_ready <= ($urandom % 3) != 0;
  end

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_up();
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic push_words(input int s, input int words, input int seed);
    for (int w = 0; w < words; w++) begin
      logic [8*BUS_BYTES-1:0] d;
      for (int b = 0; b < BUS_BYTES; b++) d[8*b +: 8] = gen(s, BUS_BYTES * w + b, seed);
      fill_valid = 1'b1; fill_data = d;
      @(negedge clk);
    end
    fill_valid = 1'b0;
  endtask

  task automatic fill(input int s, input int words, input int seed);
    wr(8'h00, 16'((s << 13) | (1 << 12)));
    push_words(s, words, seed);
    wr(8'h00, 16'(s << 13));
  endtask

  task automatic send(input int s, input int len);
    wr(8'h04, 16'(1 << s));
    wr(8'(8'h10 + 4 * s), 16'(16'h8000 | len));
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 4000 && quiet < 3; i++) begin
      @(negedge clk);
      if (!m_send && (m_busy & m_en) == '0) quiet++; else quiet = 0;
    end
  endtask

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    chk(busy_map === '0, "R1", "reset busy_map", busy_map, 0);
    chk(tx_valid === 1'b0, "R1", "reset tx_valid", tx_valid, 0);
    chk(fill_ready === 1'b0, "R1", "reset fill_ready", fill_ready, 0);

    // basic frame, length not a word multiple (R6)
    rdy_mode = 1;
    fill(0, 5, 1);
    send(0, 17);
    wait_idle();
    chk(frm_len.size() == 1 && frm_len[0] == 17, "R6", "frame length", frm_len[frm_len.size()-1], 17);
    chk(frm_first[0] == int'(gen(0, 0, 1)), "R6", "frame first byte", frm_first[0], gen(0, 0, 1));

    // busy without enable is not sent (R4); zero write ignored (R3)
    fill(5, 2, 2);
    wr(8'h04, 16'h0020);
    repeat (10) @(negedge clk);
    #2;
    chk(tx_valid === 1'b0, "R4", "busy without enable sent", tx_valid, 0);
    wr(8'h04, 16'h0000);
    #2;
    chk(busy_map[5] === 1'b1, "R3", "zero write cleared bit", busy_map[5], 1);
    wr(8'h24, 16'h8008);
    wait_idle();
    chk(frm_first[frm_first.size()-1] == int'(gen(5, 0, 2)), "R4", "slot 5 sent after enable",
        frm_first[frm_first.size()-1], gen(5, 0, 2));

    // circular order with wrap, under back-pressure (R5, R7)
    rdy_mode = 0;
    fill(1, 3, 3); fill(2, 3, 4); fill(7, 1, 5);
    wr(8'h14, 16'h8009); wr(8'h18, 16'h800C); wr(8'h2C, 16'h8004);
    frm_first.delete(); frm_len.delete();
    wr(8'h04, 16'h0086);
    repeat (6) @(negedge clk);
    rdy_mode = 2;
    wait_idle();
    chk(frm_first.size() == 3, "R5", "frame count", frm_first.size(), 3);
    if (frm_first.size() == 3) begin
      chk(frm_first[0] == int'(gen(7, 0, 5)), "R5", "order first", frm_first[0], gen(7, 0, 5));
      chk(frm_first[1] == int'(gen(1, 0, 3)), "R5", "order second", frm_first[1], gen(1, 0, 3));
      chk(frm_first[2] == int'(gen(2, 0, 4)), "R5", "order third", frm_first[2], gen(2, 0, 4));
      chk(frm_len[1] == 9, "R6", "length slot 1", frm_len[1], 9);
    end

    // length clamp (R8)
    rdy_mode = 1;
    fill(3, WPS, 6);
    send(3, 100);
    wait_idle();
    chk(frm_len[frm_len.size()-1] == SLOT_BYTES, "R8", "clamped length",
        frm_len[frm_len.size()-1], SLOT_BYTES);

    // overfill drops extra words (R2)
    wr(8'h00, 16'((4 << 13) | (1 << 12)));
    push_words(4, WPS + 4, 7);
    #2;
    chk(fill_ready === 1'b0, "R2", "fill_ready after full slot", fill_ready, 0);
    wr(8'h00, 16'(4 << 13));
    #2;
    chk(fill_ready === 1'b0, "R2", "fill_ready after close", fill_ready, 0);
    send(4, SLOT_BYTES);
    wait_idle();
    chk(frm_len[frm_len.size()-1] == SLOT_BYTES, "R2", "overfilled slot length",
        frm_len[frm_len.size()-1], SLOT_BYTES);

    // zero-length release (R9)
    n0 = frm_len.size();
    send(6, 0);
    repeat (6) @(negedge clk);
    #2;
    chk(busy_map[6] === 1'b0, "R9", "zero-length slot released", busy_map[6], 0);
    chk(frm_len.size() == n0, "R9", "zero-length bytes sent", frm_len.size(), n0);

    // slot reuse with random back-pressure (R6, R7, R9)
    rdy_mode = 2;
    fill(1, 4, 9);
    send(1, 13);
    wait_idle();
    chk(frm_len[frm_len.size()-1] == 13, "R6", "reused slot length", frm_len[frm_len.size()-1], 13);
    #2;
    chk(busy_map === '0, "R9", "all slots free at end", busy_map, 0);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule